// File: doc/BRIEF.md
# SD Card Host Bring-Up Sequencer

This block runs the host side of SD-mode card initialisation, from power-on to a selected card on a four-bit data bus. It does not serialise bits itself. It drives a command engine through a request/response handshake. For each step it presents a command index, a 32-bit argument and the expected response type. It then waits for either a response payload or a timeout indication. The command engine reports completion with `rsp_valid` even for commands that have no response.

The order of commands depends on what the card returns. The sequencer checks the echo of the interface-condition command. It polls the operating-condition command until the card reports ready, and then captures the capacity and low-voltage-accept bits. The voltage-switch command is issued only when the card accepts it, and the sequencer then waits for the DAT lines to go high. Before changing the bus width it checks whether the card reports itself locked.

The block also produces a card-clock enable strobe. The strobe runs at a slow rate during identification and at a fast rate once the card is selected. The sequencer reports:
- the card address and card identification;
- the capacity class and the voltage-switch result;
- a locked flag and a done flag;
- an error code together with the index of the command that failed.

Top module: `sd_init_seq`

## Requirements
- R1: After reset, `cmd_req` stays low until `card_tick` has pulsed `PWRUP_TICKS` times; the first request is index 0 with argument 0 and response type 0.
- R2: `card_tick` pulses once every `SLOW_DIV` clocks while `clk_fast`=0 and every `FAST_DIV` clocks while `clk_fast`=1. `clk_fast` is 0 for every command up to and including index 7, and becomes 1 only when index 7 is accepted without fault.
- R3: Index 8 is sent second, with argument `{20'b0, VHS[3:0], PATTERN[7:0]}` and response type 7. Reply bits [11:0] must equal argument bits [11:0], otherwise the block stops with `err_code`=3. A timeout stops it with `err_code`=1. In both cases `err_cmd`=8.
- R4: Every index-41 request immediately follows an index-55 request with argument 0. Its argument is always the same: bit 30 set, bit 24 set, bits [23:15] = `VWIN`, all other bits 0. Its response type is 3.
- R5: The index-41 loop ends when reply bit 31 is 1. At that point `ccs` takes bit 30 and the accept flag takes bit 24. After `MAX_OPCOND` busy replies the block stops with `err_code`=4 and `err_cmd`=41.
- R6: Index 11 (response type 1) is sent only when the accept flag is 1. After its reply, index 2 is not requested until `dat_level & DAT_MASK` is nonzero, and at that moment `vsw_done` becomes 1.
- R7: When the accept flag is 0, index 11 is skipped, index 2 follows the loop directly, and `vsw_done` stays 0.
- R8: Index 2 (response type 2) stores the 128-bit reply in `cid`. Index 3 (response type 6) stores reply bits [31:16] in `rca`. A zero address stops the block with `err_code`=5 and `err_cmd`=3.
- R9: Index 7 (response type 1) carries `{rca, 16'b0}`. If reply bit 25 is 1, `locked` and `done` rise and no further command is issued.
- R10: For an unlocked card, index 55 with `{rca, 16'b0}` is sent, then index 6 with argument 2 (four-bit bus). After both, `done` becomes 1.
- R11: Any reply to index 55, 11, 7 or 6 with a set bit among 31..26 or 24..19 stops the block with `err_code`=2 and `err_cmd` set to that index. A timeout on any command gives `err_code`=1. `done` and a nonzero `err_code` are never both high.
- R12: Once `done` or a nonzero `err_code` is reached, no further request is issued and all reported outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_tick | output | 1 | One-cycle card-clock enable strobe |
| clk_fast | output | 1 | 1 = transfer rate selected, 0 = identification rate |
| cmd_req | output | 1 | One-cycle request to the command engine |
| cmd_index | output | 6 | Command index of the request |
| cmd_arg | output | 32 | Command argument |
| cmd_rtype | output | 3 | Expected response type: 0 none, 1 R1, 2 R2, 3 R3, 6 R6, 7 R7 |
| rsp_valid | input | 1 | Engine finished the command; payload valid |
| rsp_timeout | input | 1 | Engine saw no response |
| rsp_data | input | 128 | Response payload; short replies sit in [31:0] |
| dat_level | input | 4 | Sampled DAT line levels |
| rca | output | 16 | Stored card address |
| cid | output | 128 | Stored card identification |
| ccs | output | 1 | High-capacity flag from the ready reply |
| vsw_done | output | 1 | Voltage switch completed |
| locked | output | 1 | Card reported locked at selection |
| done | output | 1 | Sequence finished successfully |
| err_code | output | 3 | 0 none, 1 no response, 2 status fault, 3 echo mismatch, 4 busy limit, 5 zero address |
| err_cmd | output | 6 | Index of the command that failed |

## Verification
The bench builds the block with `SLOW_DIV`=4, `FAST_DIV`=2 and `MAX_OPCOND`=4. With these values the power-up window takes a few hundred cycles, and both sides of the retry limit can be reached: three busy replies succeed and ten abort. A behavioural card model answers each request and compares it against a command list. The bench derives that list from the card's configured answers, covering the switch-accepted, switch-refused, locked and each abort path. A per-clock model of the strobe spacing follows `clk_fast` across the rate change.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

  typedef enum logic [3:0] {
    ST_PWR, ST_GO_IDLE, ST_IFCOND, ST_APP_OP, ST_OPCOND, ST_VSW, ST_VWAIT,
    ST_GETID, ST_GETADDR, ST_SELECT, ST_APP_BW, ST_BUSW, ST_DONE, ST_FAIL
  } step_e;

  localparam logic [2:0] ERR_NONE   = 3'd0;
  localparam logic [2:0] ERR_NORSP  = 3'd1;
  localparam logic [2:0] ERR_STATUS = 3'd2;
  localparam logic [2:0] ERR_ECHO   = 3'd3;
  localparam logic [2:0] ERR_BUSY   = 3'd4;
  localparam logic [2:0] ERR_ADDR   = 3'd5;

  localparam logic [2:0] RT_NONE = 3'd0;
  localparam logic [2:0] RT_R1   = 3'd1;
  localparam logic [2:0] RT_R2   = 3'd2;
  localparam logic [2:0] RT_R3   = 3'd3;
  localparam logic [2:0] RT_R6   = 3'd6;
  localparam logic [2:0] RT_R7   = 3'd7;

  // status error bits 31..26 and 24..19; bit 25 is the lock status, not a fault
  localparam logic [31:0] STATUS_FAULT_MASK = 32'hFDF8_0000;

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    logic [2:0]  rtype;
  } cmd_t;

  function automatic logic status_fault(input logic [31:0] st);
    return |(st & STATUS_FAULT_MASK);
  endfunction

  function automatic logic [31:0] ifcond_arg(input logic [3:0] vhs, input logic [7:0] pat);
    return {20'd0, vhs, pat};
  endfunction

  function automatic logic echo_match(input logic [31:0] r, input logic [3:0] vhs,
                                      input logic [7:0] pat);
    return r[11:0] == {vhs, pat};
  endfunction

  // fixed operating-condition argument: capacity support and low-voltage request set
  function automatic logic [31:0] opcond_arg(input logic [8:0] win);
    return {1'b0, 1'b1, 5'd0, 1'b1, win, 15'd0};
  endfunction

  function automatic cmd_t cmd_of(input step_e st, input logic [15:0] rca,
                                  input logic [3:0] vhs, input logic [7:0] pat,
                                  input logic [8:0] win);
    cmd_t c;
    c = '0;
    case (st)
      ST_GO_IDLE: c = '{idx: 6'd0,  arg: 32'd0,              rtype: RT_NONE};
      ST_IFCOND:  c = '{idx: 6'd8,  arg: ifcond_arg(vhs, pat), rtype: RT_R7};
      ST_APP_OP:  c = '{idx: 6'd55, arg: 32'd0,              rtype: RT_R1};
      ST_OPCOND:  c = '{idx: 6'd41, arg: opcond_arg(win),    rtype: RT_R3};
      ST_VSW:     c = '{idx: 6'd11, arg: 32'd0,              rtype: RT_R1};
      ST_GETID:   c = '{idx: 6'd2,  arg: 32'd0,              rtype: RT_R2};
      ST_GETADDR: c = '{idx: 6'd3,  arg: 32'd0,              rtype: RT_R6};
      ST_SELECT:  c = '{idx: 6'd7,  arg: {rca, 16'd0},       rtype: RT_R1};
      ST_APP_BW:  c = '{idx: 6'd55, arg: {rca, 16'd0},       rtype: RT_R1};
      ST_BUSW:    c = '{idx: 6'd6,  arg: 32'd2,              rtype: RT_R1};
      default:    c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sd_init_clkdiv.sv
module sd_init_clkdiv #(
  parameter int SLOW_DIV = 250,
  parameter int FAST_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  output logic tick
);
  localparam int MAXD = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CW   = $clog2(MAXD) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = fast ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
  // compare with >= so a rate change to a shorter period never skips a strobe
  assign tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= tick ? '0 : cnt + 1'b1;
  end

  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/sd_init_rsp_eval.sv
module sd_init_rsp_eval
  import sd_init_pkg::*;
#(
  parameter logic [3:0] VHS     = 4'h1,
  parameter logic [7:0] PATTERN = 8'hAA
) (
  input  step_e       step,
  input  logic        rsp_timeout,
  input  logic [31:0] rsp_short,
  output logic        ev_fail,
  output logic [2:0]  ev_code,
  output logic        ev_busy
);
  always_comb begin
    ev_fail = 1'b0;
    ev_code = ERR_NONE;
    ev_busy = 1'b0;
    if (rsp_timeout) begin
      ev_fail = 1'b1;
      ev_code = ERR_NORSP;
    end else begin
      case (step)
        ST_IFCOND: if (!echo_match(rsp_short, VHS, PATTERN)) begin
          ev_fail = 1'b1; ev_code = ERR_ECHO;
        end
        ST_APP_OP, ST_VSW, ST_SELECT, ST_APP_BW, ST_BUSW:
          if (status_fault(rsp_short)) begin
            ev_fail = 1'b1; ev_code = ERR_STATUS;
          end
        ST_OPCOND: ev_busy = !rsp_short[31];
        ST_GETADDR: if (rsp_short[31:16] == 16'd0) begin
          ev_fail = 1'b1; ev_code = ERR_ADDR;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sd_init_ctrl.sv
module sd_init_ctrl
  import sd_init_pkg::*;
#(
  parameter int         PWRUP_TICKS = 74,
  parameter int         MAX_OPCOND  = 1000,
  parameter logic [3:0] VHS         = 4'h1,
  parameter logic [7:0] PATTERN     = 8'hAA,
  parameter logic [8:0] VWIN        = 9'h1FF,
  parameter logic [3:0] DAT_MASK    = 4'b0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic         cmd_req,
  output logic [5:0]   cmd_index,
  output logic [31:0]  cmd_arg,
  output logic [2:0]   cmd_rtype,
  input  logic         rsp_valid,
  input  logic         rsp_timeout,
  input  logic [127:0] rsp_data,
  input  logic [3:0]   dat_level,
  input  logic         ev_fail,
  input  logic [2:0]   ev_code,
  input  logic         ev_busy,
  output step_e        step,
  output logic         clk_fast,
  output logic [15:0]  rca,
  output logic [127:0] cid,
  output logic         ccs,
  output logic         vsw_done,
  output logic         locked,
  output logic         done,
  output logic [2:0]   err_code,
  output logic [5:0]   err_cmd
);
  localparam int PW = $clog2(PWRUP_TICKS + 1);
  localparam int AW = $clog2(MAX_OPCOND + 1);

  logic          waiting;
  logic [PW-1:0] pwr_cnt;
  logic [AW-1:0] op_cnt;
  logic [5:0]    last_idx;
  logic          s18a;
  cmd_t          cur;
  logic          is_cmd_step;
  logic          rsp_in;
  logic          lines_high;

  assign cur         = cmd_of(step, rca, VHS, PATTERN, VWIN);
  assign is_cmd_step = !(step inside {ST_PWR, ST_VWAIT, ST_DONE, ST_FAIL});
  assign cmd_req     = is_cmd_step && !waiting;
  assign cmd_index   = cur.idx;
  assign cmd_arg     = cur.arg;
  assign cmd_rtype   = cur.rtype;
  assign rsp_in      = waiting && (rsp_valid || rsp_timeout);
  assign lines_high  = (dat_level & DAT_MASK) != 4'd0;
  assign done        = (step == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= ST_PWR;  waiting <= 1'b0; pwr_cnt <= '0; op_cnt <= '0;
      last_idx <= '0;  s18a <= 1'b0;    rca <= '0;     cid <= '0;
      ccs <= 1'b0;     vsw_done <= 1'b0; locked <= 1'b0; clk_fast <= 1'b0;
      err_code <= ERR_NONE; err_cmd <= '0;
    end else begin
      if (cmd_req) begin
        waiting  <= 1'b1;
        last_idx <= cur.idx;
      end
      case (step)
        ST_PWR: if (tick) begin
          if (pwr_cnt == PW'(PWRUP_TICKS - 1)) step <= ST_GO_IDLE;
          else pwr_cnt <= pwr_cnt + 1'b1;
        end
        ST_VWAIT: if (lines_high) begin
          vsw_done <= 1'b1;
          step     <= ST_GETID;
        end
        default: ;
      endcase
      if (rsp_in) begin
        waiting <= 1'b0;
        if (ev_fail) begin
          step <= ST_FAIL; err_code <= ev_code; err_cmd <= cur.idx;
        end else begin
          case (step)
            ST_GO_IDLE: step <= ST_IFCOND;
            ST_IFCOND:  step <= ST_APP_OP;
            ST_APP_OP:  step <= ST_OPCOND;
            ST_OPCOND:
              if (ev_busy) begin
                if (op_cnt == AW'(MAX_OPCOND - 1)) begin
                  step <= ST_FAIL; err_code <= ERR_BUSY; err_cmd <= cur.idx;
                end else begin
                  op_cnt <= op_cnt + 1'b1;
                  step   <= ST_APP_OP;
                end
              end else begin
                ccs  <= rsp_data[30];
                s18a <= rsp_data[24];
                step <= rsp_data[24] ? ST_VSW : ST_GETID;
              end
            ST_VSW:     step <= ST_VWAIT;
            ST_GETID:   begin cid <= rsp_data; step <= ST_GETADDR; end
            ST_GETADDR: begin rca <= rsp_data[31:16]; step <= ST_SELECT; end
            ST_SELECT: begin
              clk_fast <= 1'b1;
              if (rsp_data[25]) begin locked <= 1'b1; step <= ST_DONE; end
              else step <= ST_APP_BW;
            end
            ST_APP_BW:  step <= ST_BUSW;
            ST_BUSW:    step <= ST_DONE;
            default: ;
          endcase
        end
      end
    end
  end

  p_pwrup_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_index == 6'd0) |-> pwr_cnt == PW'(PWRUP_TICKS - 1));
  p_slow_ident_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_index inside {6'd0, 6'd8, 6'd41, 6'd11, 6'd2, 6'd3, 6'd7}) |-> !clk_fast);
  p_app_prefix_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_index == 6'd41) |-> last_idx == 6'd55);
  p_switch_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_index == 6'd11) |-> s18a);
  p_no_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vsw_done |-> s18a);
  p_addr_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_index == 6'd7) |-> rca != 16'd0);
  p_width_unlocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_index == 6'd6) |-> (!locked && clk_fast));
  p_done_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err_code != ERR_NONE));
  p_hold_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err_code != ERR_NONE) |=> ($stable(err_code) && $stable(rca) && $stable(locked) && !cmd_req));

endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
  import sd_init_pkg::*;
#(
  parameter int         SLOW_DIV    = 250,
  parameter int         FAST_DIV    = 4,
  parameter int         PWRUP_TICKS = 74,
  parameter int         MAX_OPCOND  = 1000,
  parameter logic [3:0] VHS         = 4'h1,
  parameter logic [7:0] PATTERN     = 8'hAA,
  parameter logic [8:0] VWIN        = 9'h1FF,
  parameter logic [3:0] DAT_MASK    = 4'b0001
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic         card_tick,
  output logic         clk_fast,
  output logic         cmd_req,
  output logic [5:0]   cmd_index,
  output logic [31:0]  cmd_arg,
  output logic [2:0]   cmd_rtype,
  input  logic         rsp_valid,
  input  logic         rsp_timeout,
  input  logic [127:0] rsp_data,
  input  logic [3:0]   dat_level,
  output logic [15:0]  rca,
  output logic [127:0] cid,
  output logic         ccs,
  output logic         vsw_done,
  output logic         locked,
  output logic         done,
  output logic [2:0]   err_code,
  output logic [5:0]   err_cmd
);
  step_e      step;
  logic       ev_fail;
  logic [2:0] ev_code;
  logic       ev_busy;

  sd_init_clkdiv #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .fast(clk_fast), .tick(card_tick));

  sd_init_rsp_eval #(.VHS(VHS), .PATTERN(PATTERN)) u_eval (
    .step(step), .rsp_timeout(rsp_timeout), .rsp_short(rsp_data[31:0]),
    .ev_fail(ev_fail), .ev_code(ev_code), .ev_busy(ev_busy));

  sd_init_ctrl #(
    .PWRUP_TICKS(PWRUP_TICKS), .MAX_OPCOND(MAX_OPCOND), .VHS(VHS),
    .PATTERN(PATTERN), .VWIN(VWIN), .DAT_MASK(DAT_MASK)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(card_tick),
    .cmd_req(cmd_req), .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_rtype(cmd_rtype),
    .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_data(rsp_data),
    .dat_level(dat_level), .ev_fail(ev_fail), .ev_code(ev_code), .ev_busy(ev_busy),
    .step(step), .clk_fast(clk_fast), .rca(rca), .cid(cid), .ccs(ccs),
    .vsw_done(vsw_done), .locked(locked), .done(done),
    .err_code(err_code), .err_cmd(err_cmd));

endmodule

// File: tb/sd_init_seq_tb_top.sv
module sd_init_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW = 4;
  localparam int FAST = 2;
  localparam int MAXOP = 4;
  localparam logic [3:0] VHS_T = 4'h1;
  localparam logic [7:0] PAT_T = 8'h5C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic card_tick, clk_fast, cmd_req, ccs, vsw_done, locked, done;
  logic [5:0] cmd_index, err_cmd;
  logic [31:0] cmd_arg;
  logic [2:0] cmd_rtype, err_code;
  logic rsp_valid = 1'b0, rsp_timeout = 1'b0;
  logic [127:0] rsp_data = '0;
  logic [3:0] dat_level = 4'd0;
  logic [15:0] rca;
  logic [127:0] cid;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_init_seq #(.SLOW_DIV(SLOW), .FAST_DIV(FAST), .PWRUP_TICKS(74), .MAX_OPCOND(MAXOP),
                .VHS(VHS_T), .PATTERN(PAT_T), .VWIN(9'h1FF), .DAT_MASK(4'b0001)) dut_i (
    .clk(clk), .rst_n(rst_n), .card_tick(card_tick), .clk_fast(clk_fast),
    .cmd_req(cmd_req), .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_rtype(cmd_rtype),
    .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_data(rsp_data),
    .dat_level(dat_level), .rca(rca), .cid(cid), .ccs(ccs), .vsw_done(vsw_done),
    .locked(locked), .done(done), .err_code(err_code), .err_cmd(err_cmd));

  int n_chk = 0, n_fail = 0;

  // card model configuration
  int busy_n; bit s18a_c, ccs_c, lock_c, echo_bad, silent8; logic [15:0] rca_c;
  logic [31:0] sel_extra; logic [127:0] cid_c;
  int exp_idx[$]; logic [31:0] exp_arg[$];
  int ticks_seen, gap, tick_err, dat_cnt;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int idx);
    case (idx)
      0: return "R1"; 8: return "R3"; 55, 41: return "R4"; 11: return "R6";
      2, 3: return "R8"; 7: return "R9"; 6: return "R10"; default: return "R12";
    endcase
  endfunction

  function automatic logic [2:0] rt_of(input int idx);
    case (idx)
      0: return 3'd0; 8: return 3'd7; 41: return 3'd3; 2: return 3'd2; 3: return 3'd6;
      default: return 3'd1;
    endcase
  endfunction

  // per-clock strobe model (R2): strobe when the spacing reaches the current ratio
  always @(negedge clk) begin
    if (!rst_n) begin gap = 1; ticks_seen = 0; end
    else begin
      if (card_tick !== (gap >= (clk_fast ? FAST : SLOW) - 1)) tick_err++;
      if (card_tick) begin gap = 0; ticks_seen++; end else gap++;
    end
  end

  task automatic serve();
    int idx; logic [31:0] arg; logic [31:0] r;
    idx = int'(cmd_index); arg = cmd_arg;
    if (idx == 0) begin
      n_chk++;
      if (ticks_seen < 74) begin
        n_fail++; $display("FAIL R1 actual=%0d expected>=74 strobes before first request", ticks_seen);
      end
    end
    if (exp_idx.size() == 0) begin
      chk("R12 unexpected request", 128'(idx), 128'hFFFF);
      return;
    end
    chk(tag_of(idx), 128'(idx), 128'(exp_idx.pop_front()));
    chk(tag_of(idx), 128'(arg), 128'(exp_arg.pop_front()));
    chk(tag_of(idx), 128'(cmd_rtype), 128'(rt_of(idx)));
    chk("R2 rate at request", 128'(clk_fast), 128'((idx == 6) || (idx == 55 && arg != 0)));
    if (idx == 2 && s18a_c) chk("R6 lines high before id", 128'(dat_level[0]), 128'd1);
    repeat (2) @(negedge clk);
    r = 32'd0;
    case (idx)
      8:  r = echo_bad ? {20'd0, arg[11:8], ~arg[7:0]} : {20'd0, arg[11:0]};
      55: r = 32'h0000_0120;
      41: if (busy_n > 0) begin busy_n--; r = 32'h00FF_8000; end
          else r = {1'b1, ccs_c, 5'd0, s18a_c, 24'hFF_8000};
      3:  r = {rca_c, 16'h0500};
      7:  r = (lock_c ? 32'h0200_0000 : 32'd0) | sel_extra;
      11: dat_cnt = 6;
      default: ;
    endcase
    if (idx == 8 && silent8) rsp_timeout = 1'b1;
    else begin
      rsp_valid = 1'b1;
      rsp_data  = (idx == 2) ? cid_c : {96'd0, r};
    end
  endtask

  // behavioural card and command engine
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0; rsp_timeout = 1'b0;
      if (dat_cnt > 0) begin dat_cnt--; if (dat_cnt == 0) dat_level = 4'b0001; end
      if (rst_n && cmd_req) serve();
    end
  end

  // reference command list derived from the card answers
  task automatic build_expect();
    int ops;
    exp_idx.delete(); exp_arg.delete();
    exp_idx.push_back(0); exp_arg.push_back(0);
    exp_idx.push_back(8); exp_arg.push_back({20'd0, VHS_T, PAT_T});
    if (silent8 || echo_bad) return;
    ops = (busy_n + 1 > MAXOP) ? MAXOP : busy_n + 1;
    for (int i = 0; i < ops; i++) begin
      exp_idx.push_back(55); exp_arg.push_back(0);
      exp_idx.push_back(41); exp_arg.push_back(32'h41FF_8000);
    end
    if (busy_n + 1 > MAXOP) return;
    if (s18a_c) begin exp_idx.push_back(11); exp_arg.push_back(0); end
    exp_idx.push_back(2); exp_arg.push_back(0);
    exp_idx.push_back(3); exp_arg.push_back(0);
    if (rca_c == 0) return;
    exp_idx.push_back(7); exp_arg.push_back({rca_c, 16'd0});
    if (lock_c || sel_extra != 0) return;
    exp_idx.push_back(55); exp_arg.push_back({rca_c, 16'd0});
    exp_idx.push_back(6); exp_arg.push_back(2);
  endtask

  task automatic run(input string name, input bit exp_done, input logic [2:0] exp_err,
                     input logic [5:0] exp_cmd);
    logic [15:0] rca_hold;
    build_expect();
    rst_n = 1'b0; dat_level = 4'd0; dat_cnt = 0; tick_err = 0;
    repeat (3) @(negedge clk);
    chk("R12 reset done", 128'(done), 0);
    chk("R11 reset err", 128'(err_code), 0);
    chk("R2 reset rate", 128'(clk_fast), 0);
    chk("R1 reset req", 128'(cmd_req), 0);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 6000 && !(done || err_code != 0); i++) @(negedge clk);
    rca_hold = rca;
    repeat (30) @(negedge clk);
    $display("scenario %s finished", name);
    chk("R11 done flag", 128'(done), 128'(exp_done));
    chk("R11 error code", 128'(err_code), 128'(exp_err));
    if (exp_err != 0) chk("R11 failing index", 128'(err_cmd), 128'(exp_cmd));
    chk("R12 list consumed", 128'(exp_idx.size()), 0);
    chk("R12 address held", 128'(rca), 128'(rca_hold));
    chk("R2 strobe spacing", 128'(tick_err), 0);
    chk("R2 final rate", 128'(clk_fast), 128'(exp_done));
    if (exp_done) begin
      chk("R8 cid", cid, cid_c);
      chk("R8 rca", 128'(rca), 128'(rca_c));
      chk("R5 ccs", 128'(ccs), 128'(ccs_c));
      chk(s18a_c ? "R6 switched" : "R7 not switched", 128'(vsw_done), 128'(s18a_c));
      chk("R9 locked", 128'(locked), 128'(lock_c));
    end
  endtask

  task automatic cfg(input int b, input bit s, input bit c, input bit l, input logic [15:0] a);
    busy_n = b; s18a_c = s; ccs_c = c; lock_c = l; rca_c = a;
    echo_bad = 0; silent8 = 0; sel_extra = 0;
    cid_c = {32'h1234_5678, 32'h9ABC_DEF0, 32'h0F1E_2D3C, a, 16'h4B5A};
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cfg(2, 1, 1, 0, 16'hB3C1); run("switch accepted R6 R10", 1, 0, 0);
    cfg(0, 0, 0, 0, 16'h0042); run("switch refused R7", 1, 0, 0);
    cfg(1, 1, 1, 1, 16'h7001); run("locked card R9", 1, 0, 0);
    cfg(0, 1, 1, 0, 16'h1111); silent8 = 1; run("no reply R3", 0, 3'd1, 6'd8);
    cfg(0, 1, 1, 0, 16'h1111); echo_bad = 1; run("echo mismatch R3", 0, 3'd3, 6'd8);
    cfg(10, 1, 1, 0, 16'h2222); run("busy limit R5", 0, 3'd4, 6'd41);
    cfg(MAXOP - 1, 0, 1, 0, 16'h3333); run("busy just under limit R5", 1, 0, 0);
    cfg(0, 0, 1, 0, 16'h4444); sel_extra = 32'h0008_0000; run("status fault R11", 0, 3'd2, 6'd7);
    cfg(0, 0, 1, 0, 16'h0000); run("zero address R8", 0, 3'd5, 6'd3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule